// File: doc/BRIEF.md
# LFSR-Coded Programmable Clock Divider

This block divides a reference clock by an integer ratio from 1 to 32768. The ratio is not held as a binary count. It is held as the state of a 15-bit maximal-length shift register. A sequential encoder accepts a binary ratio through a valid/ready handshake. It walks the shift register from a fixed seed, one shift per clock, until it reaches the code for that ratio. It then presents the code together with two loop-gain select values derived from the ratio.

The divider core loads every freshly encoded code by itself and steps its own copy of the register on each clock. It emits a one-cycle pulse whenever the register reaches the seed state, which is the terminal state. One extra reload cycle makes the output period exactly the requested ratio. The code and both gain fields are also packed into a single control word for a downstream consumer.

Handshake rules: `ratio_in` is taken on a rising clock edge where both `ratio_valid` and `ratio_ready` are high. `ratio_ready` is low from the cycle after acceptance through the cycle in which `enc_done` is high. A source that sees `ratio_ready` low must hold its request, because the block drops nothing it has not accepted and ignores the request until it is accepted.

Top module: `ldiv_top`

## Requirements
- R1: `ratio_ready` is high whenever the encoder is idle. It falls in the cycle after a request is accepted and rises again in the cycle after `enc_done`. A request presented while `ratio_ready` is low has no effect on the code that is produced.
- R2: For a ratio M from 3 to 32768, the code is the 15-bit state reached from seed 0x4000 after (32769 − M) shift steps, zero-extended to 17 bits. Each step puts bit0 XOR bit1 into bit 14 and moves bits 14..1 down to bits 13..0.
- R3: Ratio 1 gives code 0x18003 and ratio 2 gives code 0x10003. Ratio 0 and any ratio above 32768 give 0x1FFFF, all ones.
- R4: `enc_done` is high for exactly one cycle per accepted request. `code_out` changes only in a cycle in which `enc_done` is high.
- R5: From the cycle after acceptance, `sel_p` equals floor(M/2)+1 for M below 60 and 31 otherwise.
- R6: From the cycle after acceptance, `sel_i` follows the ratio M as follows. It is 1 for M > 16384, 2 for M > 8192, 4 for M > 2048, and 8 for M ≥ 501. For 60 ≤ M ≤ 500 it is 4·floor(1024/(M+9)). For M < 60 it is (M AND 0x3C)+4.
- R7: `ctl_word` carries the code in bits 16..0, `sel_p` in bits 21..17 and `sel_i` in bits 27..22.
- R8: After a code for a ratio M from 3 to 32768 is loaded, the first `div_pulse` comes M−1 cycles after the `enc_done` cycle. From then on, consecutive pulses are exactly M cycles apart, and each pulse lasts one cycle.
- R9: With code 0x18003, `div_pulse` is high on every cycle from the cycle after `enc_done`. With code 0x10003, pulses come every second cycle.
- R10: With the all-ones code, `div_pulse` stays low.
- R11: Synchronous active-high reset aborts any encoding and parks the core at the seed state without pulsing. After reset, `ratio_ready`=1, `enc_done`=0, `div_pulse`=0, `code_out`=0x1FFFF, `sel_p`=1 and `sel_i`=4.
- R12: A new `enc_done` reloads the core at once, even while it is dividing. The next pulse then follows the R8 latency for the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_valid | input | 1 | Ratio request valid |
| ratio_ready | output | 1 | Encoder can accept a ratio |
| ratio_in | input | 16 | Binary division ratio |
| enc_done | output | 1 | One-cycle strobe: code is ready and being loaded |
| code_out | output | 17 | Shift-register code of the last ratio |
| sel_p | output | 5 | Proportional gain select |
| sel_i | output | 6 | Integral gain select |
| ctl_word | output | 28 | Packed code and gain fields |
| div_pulse | output | 1 | Divided output pulse |

## Verification
Some properties can be judged from one or two neighbouring cycles, and the assertions check those on every cycle. They cover the handshake rules, the single-cycle done strobe, the rule that the code changes only with done, silence under the all-ones code, the divide-by-one pulse train, and the quiet core after reset. Whether a code matches the shift count for its ratio, and whether the pulse period equals M, depend on tens of thousands of cycles. Only the bench scenarios can show those: they sweep the gain fields over every ratio from 0 to 700 plus the range boundaries, and they measure latency and period for ratios 1, 2, 3, 20 and 32768.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;
  localparam int CODE_W    = 15;
  localparam int RATIO_W   = CODE_W + 1;
  localparam int FIELD_W   = CODE_W + 2;
  localparam int P_W       = 5;
  localparam int I_W       = 6;
  localparam int P_LSB     = FIELD_W;
  localparam int I_LSB     = FIELD_W + P_W;
  localparam int CTL_W     = FIELD_W + P_W + I_W;
  localparam int MAX_RATIO = 1 << CODE_W;

  localparam logic [CODE_W-1:0]  SEED      = CODE_W'(1) << (CODE_W - 1);
  localparam logic [FIELD_W-1:0] CODE_DIV1 = FIELD_W'(17'h18003);
  localparam logic [FIELD_W-1:0] CODE_DIV2 = FIELD_W'(17'h10003);
  localparam logic [FIELD_W-1:0] CODE_OFF  = '1;

  // One shift of the ratio register: feedback from the two low bits.
  function automatic logic [CODE_W-1:0] lfsr_step(input logic [CODE_W-1:0] x);
    return {x[0] ^ x[1], x[CODE_W-1:1]};
  endfunction

  // Ratios that skip the shift walk.
  function automatic logic is_fixed(input logic [RATIO_W-1:0] m);
    return (m < RATIO_W'(3)) || (m > RATIO_W'(MAX_RATIO));
  endfunction

  function automatic logic [FIELD_W-1:0] fixed_code(input logic [RATIO_W-1:0] m);
    if (m == RATIO_W'(1))      return CODE_DIV1;
    else if (m == RATIO_W'(2)) return CODE_DIV2;
    else                       return CODE_OFF;
  endfunction
endpackage

// File: rtl/ldiv_encoder.sv
module ldiv_encoder
  import ldiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RATIO_W-1:0] in_ratio,
  output logic [RATIO_W-1:0] ratio_q,
  output logic [FIELD_W-1:0] code,
  output logic               done
);
  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_FIN} enc_state_t;

  enc_state_t         state;
  logic [CODE_W-1:0]  work;
  logic [RATIO_W-1:0] remain;
  logic [FIELD_W-1:0] result;
  logic [RATIO_W-1:0] steps;
  logic [CODE_W-1:0]  work_nx;

  assign steps   = RATIO_W'(MAX_RATIO + 1) - in_ratio;
  assign work_nx = lfsr_step(work);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= E_IDLE;
      work    <= SEED;
      remain  <= '0;
      result  <= CODE_OFF;
      ratio_q <= '0;
    end else begin
      unique case (state)
        E_IDLE: begin
          if (in_valid) begin
            ratio_q <= in_ratio;
            if (is_fixed(in_ratio)) begin
              result <= fixed_code(in_ratio);
              state  <= E_FIN;
            end else begin
              work   <= SEED;
              remain <= steps;
              state  <= E_SHIFT;
            end
          end
        end
        E_SHIFT: begin
          work   <= work_nx;
          remain <= remain - RATIO_W'(1);
          if (remain == RATIO_W'(1)) begin
            result <= {{(FIELD_W-CODE_W){1'b0}}, work_nx};
            state  <= E_FIN;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  assign in_ready = (state == E_IDLE);
  assign done     = (state == E_FIN);
  assign code     = result;
endmodule

// File: rtl/ldiv_gain.sv
module ldiv_gain
  import ldiv_pkg::*;
(
  input  logic [RATIO_W-1:0] ratio,
  output logic [P_W-1:0]     sel_p,
  output logic [I_W-1:0]     sel_i
);
  localparam logic [RATIO_W-1:0] P_KNEE = RATIO_W'(60);
  localparam logic [RATIO_W-1:0] I_MID  = RATIO_W'(501);

  logic [RATIO_W-1:0] quot;

  always_comb begin
    quot = '0;
    if (ratio < P_KNEE) sel_p = P_W'(ratio >> 1) + P_W'(1);
    else                sel_p = '1;

    if (ratio > RATIO_W'(16384))      sel_i = I_W'(1);
    else if (ratio > RATIO_W'(8192))  sel_i = I_W'(2);
    else if (ratio > RATIO_W'(2048))  sel_i = I_W'(4);
    else if (ratio >= I_MID)          sel_i = I_W'(8);
    else if (ratio >= P_KNEE) begin
      quot  = RATIO_W'(1024) / (ratio + RATIO_W'(9));
      sel_i = I_W'(quot << 2);
    end else begin
      sel_i = I_W'((ratio & RATIO_W'(16'h003C)) + RATIO_W'(4));
    end
  end
endmodule

// File: rtl/ldiv_core.sv
module ldiv_core
  import ldiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FIELD_W-1:0] code,
  output logic               pulse
);
  typedef enum logic [1:0] {C_STOP, C_DIV1, C_DIV2, C_RUN} core_mode_t;

  core_mode_t         mode;
  logic [CODE_W-1:0]  shreg;
  logic [CODE_W-1:0]  reload;
  logic               gap;
  logic               phase;
  core_mode_t         mode_dec;

  always_comb begin
    if (code == CODE_DIV1)                 mode_dec = C_DIV1;
    else if (code == CODE_DIV2)            mode_dec = C_DIV2;
    else if (code[FIELD_W-1:CODE_W] != '0) mode_dec = C_STOP;
    else                                   mode_dec = C_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= C_STOP;
      shreg  <= SEED;
      reload <= SEED;
      gap    <= 1'b0;
      phase  <= 1'b0;
    end else if (load) begin
      mode   <= mode_dec;
      shreg  <= code[CODE_W-1:0];
      reload <= code[CODE_W-1:0];
      gap    <= 1'b0;
      phase  <= 1'b0;
    end else begin
      unique case (mode)
        C_RUN: begin
          if (gap) begin
            shreg <= reload;
            gap   <= 1'b0;
          end else if (shreg == SEED) begin
            gap <= 1'b1;
          end else begin
            shreg <= lfsr_step(shreg);
          end
        end
        C_DIV2:  phase <= ~phase;
        default: ;
      endcase
    end
  end

  assign pulse = ((mode == C_RUN) && !gap && (shreg == SEED)) ||
                 (mode == C_DIV1) ||
                 ((mode == C_DIV2) && phase);
endmodule

// File: rtl/ldiv_top.sv
module ldiv_top
  import ldiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ratio_valid,
  output logic               ratio_ready,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               enc_done,
  output logic [FIELD_W-1:0] code_out,
  output logic [P_W-1:0]     sel_p,
  output logic [I_W-1:0]     sel_i,
  output logic [CTL_W-1:0]   ctl_word,
  output logic               div_pulse
);
  logic [RATIO_W-1:0] ratio_q;

  ldiv_encoder u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ratio_valid),
    .in_ready (ratio_ready),
    .in_ratio (ratio_in),
    .ratio_q  (ratio_q),
    .code     (code_out),
    .done     (enc_done)
  );

  ldiv_gain u_gain (
    .ratio (ratio_q),
    .sel_p (sel_p),
    .sel_i (sel_i)
  );

  ldiv_core u_core (
    .clk   (clk),
    .rst   (rst),
    .load  (enc_done),
    .code  (code_out),
    .pulse (div_pulse)
  );

  assign ctl_word = {sel_i, sel_p, code_out};
endmodule

// File: rtl/ldiv_checker.sv
module ldiv_checker
  import ldiv_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ratio_valid,
  input logic               ratio_ready,
  input logic               enc_done,
  input logic [FIELD_W-1:0] code_out,
  input logic [P_W-1:0]     sel_p,
  input logic               div_pulse
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ratio_valid && ratio_ready) |=> !ratio_ready); // R1

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    enc_done |=> ratio_ready); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    enc_done |=> !enc_done); // R4

  AST_CODE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_out) |-> enc_done); // R4

  AST_P_NONZERO: assert property (@(posedge clk) disable iff (rst)
    enc_done |-> (sel_p != '0)); // R5

  AST_DIV1_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (enc_done && code_out == CODE_DIV1) |=> div_pulse); // R9

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
    (enc_done && code_out == CODE_OFF) |=> !div_pulse); // R10

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !div_pulse); // R11
endmodule

bind ldiv_top ldiv_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .ratio_valid (ratio_valid),
  .ratio_ready (ratio_ready),
  .enc_done    (enc_done),
  .code_out    (code_out),
  .sel_p       (sel_p),
  .div_pulse   (div_pulse)
);

// File: tb/sim_ldiv_top.sv
`timescale 1ns/1ps
module sim_ldiv_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ratio_valid = 1'b0;
  logic        ratio_ready;
  logic [15:0] ratio_in = '0;
  logic        enc_done;
  logic [16:0] code_out;
  logic [4:0]  sel_p;
  logic [5:0]  sel_i;
  logic [27:0] ctl_word;
  logic        div_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  localparam int WD_LIMIT = 195000;

  always #2.5 clk = ~clk;

  ldiv_top u0 (
    .clk(clk), .rst(rst), .ratio_valid(ratio_valid), .ratio_ready(ratio_ready),
    .ratio_in(ratio_in), .enc_done(enc_done), .code_out(code_out),
    .sel_p(sel_p), .sel_i(sel_i), .ctl_word(ctl_word), .div_pulse(div_pulse)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WD_LIMIT) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int m);
    int x;
    if (m == 0 || m > 32768) return 32'h1FFFF;
    if (m == 1) return 32'h18003;
    if (m == 2) return 32'h10003;
    x = 32'h4000;
    for (int i = m; i <= 32768; i++)
      x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 32'h3FFF);
    return x;
  endfunction

  function automatic int exp_p(input int m);
    return (m < 60) ? (m / 2 + 1) : 31;
  endfunction

  function automatic int exp_i(input int m);
    if (m > 16384) return 1;
    if (m > 8192)  return 2;
    if (m > 2048)  return 4;
    if (m >= 501)  return 8;
    if (m >= 60)   return 4 * (1024 / (m + 9));
    return (m & 32'h3C) + 4;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ratio_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Returns at the negedge after the accepting edge.
  task automatic send(input int m);
    int guard = 0;
    while (!ratio_ready && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    ratio_in    = 16'(m);
    ratio_valid = 1'b1;
    @(negedge clk);
    ratio_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (!enc_done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    seen = enc_done;
  endtask

  task automatic wait_pulse(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse && n < lim);
  endtask

  task automatic run_ratio(input int m, input int periods, input string req);
    bit seen;
    int n;
    send(m);
    wait_done(seen);
    chk(seen, "R4 done seen", int'(seen), 1);
    chk(code_out == 17'(exp_code(m)), "R2 code", int'(code_out), exp_code(m));
    chk(ctl_word[16:0] == 17'(exp_code(m)), "R7 code field", int'(ctl_word[16:0]), exp_code(m));
    wait_pulse(n, m + 8);
    chk(n == m - 1, {req, " first pulse latency"}, n, m - 1);
    for (int k = 0; k < periods; k++) begin
      wait_pulse(n, m + 8);
      chk(n == m, "R8 period", n, m);
    end
    @(negedge clk);
    chk(!div_pulse, "R8 pulse width", int'(div_pulse), 0);
  endtask

  initial begin
    bit seen;
    int n;
    int pc;
    int extra[9] = '{2047, 2048, 2049, 8192, 8193, 16384, 16385, 32768, 40000};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(ratio_ready, "R11 ready", int'(ratio_ready), 1);
    chk(!enc_done, "R11 done", int'(enc_done), 0);
    chk(!div_pulse, "R11 pulse", int'(div_pulse), 0);
    chk(code_out == 17'h1FFFF, "R11 code", int'(code_out), 32'h1FFFF);
    chk(sel_p == 5'd1 && sel_i == 6'd4, "R11 gains", int'({sel_p, sel_i}), (1 << 6) | 4);

    // R5/R6/R7 sweep of gain fields; reset aborts each encode (R11)
    for (int m = 0; m <= 709; m++) begin
      int mm = (m <= 700) ? m : extra[m - 701];
      send(mm);
      chk(sel_p == 5'(exp_p(mm)), "R5 sel_p", int'(sel_p), exp_p(mm));
      chk(sel_i == 6'(exp_i(mm)), "R6 sel_i", int'(sel_i), exp_i(mm));
      chk(ctl_word[21:17] == 5'(exp_p(mm)) && ctl_word[27:22] == 6'(exp_i(mm)),
          "R7 gain fields", int'(ctl_word[27:17]), (exp_i(mm) << 5) | exp_p(mm));
      if (mm == 500) chk(!ratio_ready, "R1 busy after accept", int'(ratio_ready), 0);
      do_reset();
    end
    @(negedge clk);
    chk(ratio_ready && !enc_done, "R11 abort leaves idle", int'(ratio_ready), 1);

    // Largest ratio
    run_ratio(32768, 1, "R8");

    // Ratio 3 with a competing request held while busy (R1), then reload (R12)
    send(3);
    ratio_in = 16'd500;
    ratio_valid = 1'b1;
    repeat (50) begin
      @(negedge clk);
    end
    chk(!ratio_ready, "R1 ready low while busy", int'(ratio_ready), 0);
    ratio_valid = 1'b0;
    wait_done(seen);
    chk(code_out == 17'(exp_code(3)), "R1 ignored request, R2 code", int'(code_out), exp_code(3));
    wait_pulse(n, 16);
    chk(n == 2, "R12 first pulse latency", n, 2);
    for (int k = 0; k < 3; k++) begin
      wait_pulse(n, 16);
      chk(n == 3, "R8 period 3", n, 3);
    end
    @(negedge clk);
    @(negedge clk);
    chk(ratio_ready, "R1 ready after done", int'(ratio_ready), 1);

    run_ratio(20, 3, "R12");

    // Ratio 1 (R3, R9)
    send(1);
    wait_done(seen);
    chk(code_out == 17'h18003, "R3 code ratio 1", int'(code_out), 32'h18003);
    pc = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      pc += int'(div_pulse);
    end
    chk(pc == 8, "R9 divide by one", pc, 8);

    // Ratio 2 (R3, R9)
    send(2);
    wait_done(seen);
    chk(code_out == 17'h10003, "R3 code ratio 2", int'(code_out), 32'h10003);
    wait_pulse(n, 8);
    for (int k = 0; k < 4; k++) begin
      wait_pulse(n, 8);
      chk(n == 2, "R9 divide by two", n, 2);
    end

    // Ratio 0 and out of range (R3, R10)
    send(0);
    wait_done(seen);
    chk(code_out == 17'h1FFFF, "R3 code ratio 0", int'(code_out), 32'h1FFFF);
    pc = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      pc += int'(div_pulse);
    end
    chk(pc == 0, "R10 no pulses", pc, 0);
    send(40000);
    wait_done(seen);
    chk(code_out == 17'h1FFFF, "R3 code above range", int'(code_out), 32'h1FFFF);
    chk(seen, "R4 done for fixed code", int'(seen), 1);

    summary();
    $finish;
  end
endmodule